// File: doc/BRIEF.md
# Deferred FP Exception Bounce Controller

This controller sits beside a floating-point execution unit and keeps track of operations the hardware could not finish on its own. When the unit reports that a completed operation raised an exception, or was unsupported, the controller records that operation as pending. It captures a syndrome naming the operation, its destination register and a cause code, and it tags the destination register. The core then carries on. Later instructions that do not touch the tagged register issue and retire normally. The first later instruction that reads or writes a tagged register is stalled, and the controller asks the core to take the undefined-instruction exception, so that software support code runs. The bounce is therefore imprecise: it lands on a later instruction, not on the one that faulted.

Moves between the core and the three FP system registers serialize. These registers are the identification word, the status/control word and the exception control word. A move waits until every accepted FP instruction has reported completion, so any exception it raised is already visible in the exception control word when the move transfers. Software reads the syndrome and then clears the pending state by writing the exception control word with its top bit at zero.

Top module: `fp_bounce_ctl`

## Requirements
- R1: After reset, `ecr` is all zeros, `bounce_req` is 0, and `iss_stall` is 0 while `iss_valid` is 0.
- R2: A completion with `cmp_valid` and `cmp_exc` high, while nothing is pending, sets `ecr[31]` from the next cycle on. In the same cycle it loads `ecr[11:0]` with {op[11:8], destination register[7:3], cause[2:0]}, and it tags the destination register.
- R3: While `ecr[31]` is 1, a further exception completion changes neither `ecr` nor the register tags. An issue that uses only that second destination register is accepted without a bounce.
- R4: An issue whose `iss_src_a`, `iss_src_b` or `iss_dst` names a tagged register raises `iss_stall` in the same cycle. It also raises `bounce_req` for exactly one cycle, in the following cycle.
- R5: While an exception is pending, an issue that uses no tagged register is accepted (`iss_stall` low) and counts as in flight.
- R6: Once a bounce has been raised, `iss_stall` stays high whenever `iss_valid` is high, up to and including the cycle in which `bounce_ack` is sampled. After that cycle no further bounce is raised unless a tagged register is hit again.
- R7: A system-register move (`sys_valid`) gets `sys_done` only in a cycle in which every accepted instruction has already completed. Until then it waits with `sys_done` low.
- R8: In the transfer cycle, `sys_rdata` returns the value selected by `sys_sel`: 0 the identification word (parameter `ID_WORD`), 1 the status/control word, 2 `ecr`, 3 zero. A write to selector 1 stores `sys_wdata`.
- R9: A write to selector 0 serializes like any move but changes nothing. Later reads of selector 0 still return `ID_WORD`.
- R10: A write to selector 2 with `sys_wdata[31]` = 0 clears `ecr` and all register tags from the next cycle on. With `sys_wdata[31]` = 1 the write changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | FP instruction offered for issue |
| iss_op | input | 4 | Operation encoding of the issuing instruction |
| iss_src_a | input | 5 | First source register |
| iss_src_b | input | 5 | Second source register |
| iss_dst | input | 5 | Destination register |
| iss_stall | output | 1 | Issue held this cycle (instruction not accepted) |
| bounce_req | output | 1 | One-cycle request to take the undefined-instruction exception |
| bounce_ack | input | 1 | Core has taken the bounce |
| cmp_valid | input | 1 | Execution unit reports one instruction complete |
| cmp_op | input | 4 | Operation encoding of the completing instruction |
| cmp_dst | input | 5 | Destination register of the completing instruction |
| cmp_exc | input | 1 | Completion needs software support |
| cmp_cause | input | 3 | Exception cause code |
| sys_valid | input | 1 | System-register move requested |
| sys_write | input | 1 | 1 = write to register, 0 = read |
| sys_sel | input | 2 | Register selector: 0 ID, 1 status/control, 2 exception control |
| sys_wdata | input | 32 | Write data |
| sys_done | output | 1 | Move transfers this cycle |
| sys_rdata | output | 32 | Read data, valid with `sys_done` |
| ecr | output | 32 | Exception control word: bit 31 pending, bits 11:0 syndrome |

## Verification
`iss_stall`, `sys_done` and `sys_rdata` follow their inputs in the same cycle. `bounce_req`, `ecr`, the register tags and the in-flight count change one clock edge after the cycle that causes them. The bench drives inputs just after a rising edge and samples at the falling edge. In each cycle it compares the outputs with a behavioural model whose state holds the values registered at the previous edge, and only then advances the model. Each result is therefore checked in the exact cycle it is due, neither earlier nor later.

// File: rtl/fpb_pkg.sv
package fpb_pkg;

    localparam int unsigned NREG    = 32;
    localparam int unsigned REG_W   = $clog2(NREG);
    localparam int unsigned OP_W    = 4;
    localparam int unsigned CAUSE_W = 3;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned SYN_W   = OP_W + REG_W + CAUSE_W;

    typedef enum logic [1:0] {
        SEL_IDENT = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_EXC   = 2'd2,
        SEL_VOID  = 2'd3
    } sysreg_e;

    typedef struct packed {
        logic [OP_W-1:0]    op;
        logic [REG_W-1:0]   dst;
        logic [CAUSE_W-1:0] cause;
    } syndrome_t;

endpackage

// File: rtl/fpb_tag_file.sv
module fpb_tag_file
    import fpb_pkg::*;
#(
    parameter int unsigned N_TAGS = NREG,
    parameter int unsigned IDX_W  = $clog2(N_TAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_all,
    input  logic [IDX_W-1:0] probe_a,
    input  logic [IDX_W-1:0] probe_b,
    input  logic [IDX_W-1:0] probe_d,
    output logic             any_hit
);

    logic [N_TAGS-1:0] tags_d, tags_q;
    logic [N_TAGS-1:0] hit_vec;

    always_comb begin
        tags_d = tags_q;
        if (set_en) tags_d[set_idx] = 1'b1;
        if (clr_all) tags_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tags_q <= '0;
        else        tags_q <= tags_d;
    end

    for (genvar i = 0; i < N_TAGS; i++) begin : g_probe
        localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
        assign hit_vec[i] = tags_q[i] &
                            ((probe_a == IDX) | (probe_b == IDX) | (probe_d == IDX));
    end

    assign any_hit = |hit_vec;

endmodule

// File: rtl/fpb_drain_counter.sv
module fpb_drain_counter #(
    parameter int unsigned CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic idle
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        case ({inc, dec})
            2'b10:   cnt_d = cnt_q + CNT_W'(1);
            2'b01:   cnt_d = cnt_q - CNT_W'(1);
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign idle = (cnt_q == '0);

endmodule

// File: rtl/fp_bounce_ctl.sv
module fp_bounce_ctl
    import fpb_pkg::*;
#(
    parameter logic [31:0] ID_WORD  = 32'h0F1D_0003,
    parameter int unsigned INFL_W   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        iss_valid,
    input  logic [3:0]  iss_op,
    input  logic [4:0]  iss_src_a,
    input  logic [4:0]  iss_src_b,
    input  logic [4:0]  iss_dst,
    output logic        iss_stall,
    output logic        bounce_req,
    input  logic        bounce_ack,
    input  logic        cmp_valid,
    input  logic [3:0]  cmp_op,
    input  logic [4:0]  cmp_dst,
    input  logic        cmp_exc,
    input  logic [2:0]  cmp_cause,
    input  logic        sys_valid,
    input  logic        sys_write,
    input  logic [1:0]  sys_sel,
    input  logic [31:0] sys_wdata,
    output logic        sys_done,
    output logic [31:0] sys_rdata,
    output logic [31:0] ecr
);

    localparam int unsigned PAD_W = DATA_W - 1 - SYN_W;

    typedef struct packed {
        logic              await_ack;
        logic              bounce;
        logic              pend;
        syndrome_t         syn;
        logic [DATA_W-1:0] ctrl;
    } state_t;

    state_t st_d, st_q;

    logic    tag_hit;
    logic    drained;
    logic    accept;
    logic    sys_go;
    logic    exc_take;
    logic    exc_clear;
    sysreg_e sel;

    assign sel       = sysreg_e'(sys_sel);
    assign iss_stall = iss_valid & (tag_hit | st_q.await_ack);
    assign accept    = iss_valid & ~iss_stall;
    assign sys_go    = sys_valid & drained;
    assign exc_take  = cmp_valid & cmp_exc & ~st_q.pend;
    assign exc_clear = sys_go & sys_write & (sel == SEL_EXC) & ~sys_wdata[DATA_W-1];

    fpb_tag_file #(
        .N_TAGS (NREG),
        .IDX_W  (REG_W)
    ) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (exc_take),
        .set_idx (cmp_dst),
        .clr_all (exc_clear),
        .probe_a (iss_src_a),
        .probe_b (iss_src_b),
        .probe_d (iss_dst),
        .any_hit (tag_hit)
    );

    fpb_drain_counter #(
        .CNT_W (INFL_W)
    ) u_drain (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (accept),
        .dec   (cmp_valid),
        .idle  (drained)
    );

    always_comb begin
        st_d = st_q;

        // bounce request and acknowledge wait
        st_d.bounce = iss_valid & tag_hit & ~st_q.await_ack;
        if (st_q.await_ack && bounce_ack) begin
            st_d.await_ack = 1'b0;
        end else if (iss_valid && tag_hit && !st_q.await_ack) begin
            st_d.await_ack = 1'b1;
        end

        // exception capture, at most one outstanding
        if (exc_take) begin
            st_d.pend      = 1'b1;
            st_d.syn.op    = cmp_op;
            st_d.syn.dst   = cmp_dst;
            st_d.syn.cause = cmp_cause;
        end
        if (exc_clear) begin
            st_d.pend = 1'b0;
            st_d.syn  = '0;
        end

        // status/control register write
        if (sys_go && sys_write && sel == SEL_CTRL) begin
            st_d.ctrl = sys_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ecr        = {st_q.pend, {PAD_W{1'b0}}, st_q.syn};
    assign bounce_req = st_q.bounce;
    assign sys_done   = sys_go;

    always_comb begin
        case (sel)
            SEL_IDENT: sys_rdata = ID_WORD;
            SEL_CTRL:  sys_rdata = st_q.ctrl;
            SEL_EXC:   sys_rdata = ecr;
            default:   sys_rdata = '0;
        endcase
    end

endmodule

// File: rtl/fpb_checker.sv
module fpb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        iss_valid,
    input logic        iss_stall,
    input logic        bounce_req,
    input logic        cmp_valid,
    input logic        cmp_exc,
    input logic        sys_done,
    input logic        sys_write,
    input logic [1:0]  sys_sel,
    input logic [31:0] sys_wdata,
    input logic [31:0] ecr
);

    logic clr_now;
    assign clr_now = sys_done & sys_write & (sys_sel == 2'd2) & ~sys_wdata[31];

    assert_bounce_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bounce_req |=> !bounce_req);

    assert_stall_while_bounce_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bounce_req && iss_valid) |-> iss_stall);

    assert_pend_from_exc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ecr[31]) |-> $past(cmp_valid && cmp_exc));

    assert_pend_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ecr[31] && !clr_now) |=> $stable(ecr));

    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now |=> (ecr == 32'd0));

endmodule

bind fp_bounce_ctl fpb_checker u_fpb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_stall  (iss_stall),
    .bounce_req (bounce_req),
    .cmp_valid  (cmp_valid),
    .cmp_exc    (cmp_exc),
    .sys_done   (sys_done),
    .sys_write  (sys_write),
    .sys_sel    (sys_sel),
    .sys_wdata  (sys_wdata),
    .ecr        (ecr)
);

// File: tb/tb_fp_bounce_ctl.sv
`timescale 1ns/1ps
module tb_fp_bounce_ctl;

    localparam logic [31:0] IDW = 32'h0F1D_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 0, bounce_ack = 0, cmp_valid = 0, cmp_exc = 0;
    logic        sys_valid = 0, sys_write = 0;
    logic [3:0]  iss_op = 0, cmp_op = 0;
    logic [4:0]  iss_src_a = 0, iss_src_b = 0, iss_dst = 0, cmp_dst = 0;
    logic [2:0]  cmp_cause = 0;
    logic [1:0]  sys_sel = 0;
    logic [31:0] sys_wdata = 0;
    logic        iss_stall, bounce_req, sys_done;
    logic [31:0] sys_rdata, ecr;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    fp_bounce_ctl #(.ID_WORD(IDW)) dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_src_a(iss_src_a),
        .iss_src_b(iss_src_b), .iss_dst(iss_dst), .iss_stall(iss_stall),
        .bounce_req(bounce_req), .bounce_ack(bounce_ack),
        .cmp_valid(cmp_valid), .cmp_op(cmp_op), .cmp_dst(cmp_dst),
        .cmp_exc(cmp_exc), .cmp_cause(cmp_cause),
        .sys_valid(sys_valid), .sys_write(sys_write), .sys_sel(sys_sel),
        .sys_wdata(sys_wdata), .sys_done(sys_done), .sys_rdata(sys_rdata),
        .ecr(ecr)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit [31:0] m_tag;
    bit        m_pend, m_wait, m_bounce;
    bit [11:0] m_syn;
    int        m_infl;
    bit [31:0] m_ctrl;
    bit        mon_en = 0;

    always @(negedge clk) begin
        bit hit, stall, done, acc;
        bit [31:0] exp_ecr, exp_rd;
        if (!rst_n) begin
            m_tag = 0; m_pend = 0; m_wait = 0; m_bounce = 0;
            m_syn = 0; m_infl = 0; m_ctrl = 0;
        end else begin
            hit   = iss_valid && (m_tag[iss_src_a] || m_tag[iss_src_b] || m_tag[iss_dst]);
            stall = iss_valid && (hit || m_wait);
            acc   = iss_valid && !stall;
            done  = sys_valid && (m_infl == 0);
            exp_ecr = {m_pend, 19'd0, m_syn};
            case (sys_sel)
                2'd0: exp_rd = IDW;
                2'd1: exp_rd = m_ctrl;
                2'd2: exp_rd = exp_ecr;
                default: exp_rd = 0;
            endcase
            if (mon_en) begin
                check("R2 R3 R10 ecr", ecr, exp_ecr);
                check("R4 R5 R6 iss_stall", {31'd0, iss_stall}, {31'd0, stall});
                check("R4 R6 bounce_req", {31'd0, bounce_req}, {31'd0, m_bounce});
                check("R7 sys_done", {31'd0, sys_done}, {31'd0, done});
                if (done) check("R8 R9 sys_rdata", sys_rdata, exp_rd);
            end
            // advance model to the state after the coming edge
            m_bounce = hit && !m_wait;
            if (m_wait && bounce_ack) m_wait = 0;
            else if (hit && !m_wait) m_wait = 1;
            m_infl = m_infl + (acc ? 1 : 0) - (cmp_valid ? 1 : 0);
            if (cmp_valid && cmp_exc && !m_pend) begin
                m_pend = 1;
                m_syn = {cmp_op, cmp_dst, cmp_cause};
                m_tag[cmp_dst] = 1;
            end
            if (done && sys_write && sys_sel == 2'd2 && !sys_wdata[31]) begin
                m_pend = 0; m_syn = 0; m_tag = 0;
            end
            if (done && sys_write && sys_sel == 2'd1) m_ctrl = sys_wdata;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic issue(input logic [3:0] op, input logic [4:0] a, input logic [4:0] b,
                         input logic [4:0] d);
        iss_valid = 1; iss_op = op; iss_src_a = a; iss_src_b = b; iss_dst = d;
        step();
        iss_valid = 0;
    endtask

    // dependent issue: hold while stalled, then acknowledge the bounce (R4, R6)
    task automatic issue_dep(input logic [4:0] a, input logic [4:0] b, input logic [4:0] d);
        iss_valid = 1; iss_op = 4'h2; iss_src_a = a; iss_src_b = b; iss_dst = d;
        repeat (4) step();
        iss_valid = 0; bounce_ack = 1;
        step();
        bounce_ack = 0;
        step();
    endtask

    task automatic complete(input logic [3:0] op, input logic [4:0] d, input logic exc,
                            input logic [2:0] cause);
        cmp_valid = 1; cmp_op = op; cmp_dst = d; cmp_exc = exc; cmp_cause = cause;
        step();
        cmp_valid = 0; cmp_exc = 0;
    endtask

    task automatic sysmove(input logic wr, input logic [1:0] sel, input logic [31:0] data);
        sys_valid = 1; sys_write = wr; sys_sel = sel; sys_wdata = data;
        forever begin
            @(negedge clk);
            if (sys_done) break;
        end
        @(posedge clk); #1;
        sys_valid = 0; sys_write = 0;
    endtask

    initial begin
        #(5.0 * 20000);
        fails++;
        $display("FAIL watchdog: actual run still busy, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check("R1 ecr after reset", ecr, 32'd0);
        check("R1 bounce_req after reset", {31'd0, bounce_req}, 32'd0);
        check("R1 iss_stall after reset", {31'd0, iss_stall}, 32'd0);
        mon_en = 1;
        step();

        // R8, R9: register access
        sysmove(0, 2'd0, 0);
        sysmove(1, 2'd1, 32'hA5A5_0F0F);
        sysmove(0, 2'd1, 0);
        sysmove(1, 2'd0, 32'h1234_5678);
        sysmove(0, 2'd0, 0);
        sysmove(0, 2'd3, 0);

        // R7: move waits for three in-flight instructions
        issue(4'h1, 5'd10, 5'd11, 5'd1);
        issue(4'h1, 5'd12, 5'd13, 5'd2);
        issue(4'h3, 5'd14, 5'd15, 5'd3);
        fork
            sysmove(0, 2'd1, 0);
            begin
                repeat (2) step();
                complete(4'h1, 5'd1, 0, 0);
                step();
                complete(4'h1, 5'd2, 0, 0);
                complete(4'h3, 5'd3, 0, 0);
            end
        join

        // R2: exception on register 5
        issue(4'h7, 5'd20, 5'd21, 5'd5);
        step();
        complete(4'h7, 5'd5, 1, 3'd3);
        step();
        check("R2 pending bit", {31'd0, ecr[31]}, 32'd1);
        check("R2 syndrome", {20'd0, ecr[11:0]}, {20'd0, 4'h7, 5'd5, 3'd3});

        // R5: independent instruction retires past the fault
        issue(4'h1, 5'd1, 5'd2, 5'd6);
        complete(4'h1, 5'd6, 0, 0);
        sysmove(0, 2'd2, 0);

        // R4, R6: dependence through each operand position
        issue_dep(5'd1, 5'd5, 5'd7);
        issue_dep(5'd5, 5'd2, 5'd7);
        issue_dep(5'd1, 5'd2, 5'd5);

        // R3: second exception ignored while one pending
        issue(4'h9, 5'd1, 5'd2, 5'd9);
        complete(4'h9, 5'd9, 1, 3'd6);
        step();
        check("R3 syndrome kept", {20'd0, ecr[11:0]}, {20'd0, 4'h7, 5'd5, 3'd3});
        issue(4'h1, 5'd9, 5'd9, 5'd9);
        complete(4'h1, 5'd9, 0, 0);

        // R10: write with top bit set has no effect, then clear
        sysmove(1, 2'd2, 32'h8000_0000);
        step();
        check("R10 no clear with bit31=1", {31'd0, ecr[31]}, 32'd1);
        sysmove(1, 2'd2, 32'h0000_0000);
        check("R10 cleared", ecr, 32'd0);
        issue(4'h1, 5'd5, 5'd5, 5'd5);
        complete(4'h1, 5'd5, 0, 0);

        // new exception after clear captured again (R2)
        issue(4'hC, 5'd3, 5'd4, 5'd31);
        complete(4'hC, 5'd31, 1, 3'd1);
        issue_dep(5'd31, 5'd0, 5'd0);
        sysmove(0, 2'd2, 0);
        sysmove(1, 2'd2, 32'h0);
        repeat (3) step();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule